// File: doc/BRIEF.md
# Multi-mode legacy UART transmitter

This block is the transmit half of a classic microcontroller serial port. Software loads a byte through a one-cycle write strobe, and the block sends it in one of four frame formats selected by a 2-bit mode input. Mode 0 is a synchronous shift mode: eight data bits leave on the serial line while a second pin supplies the shift clock. Modes 1 to 3 are asynchronous. Mode 1 sends a 10-bit frame. Modes 2 and 3 send an 11-bit frame whose ninth data bit comes from a separate control input.

Mode 0 and mode 2 take their bit timing from internal dividers on the system clock. Mode 2 offers a fast and a slow rate. Modes 1 and 3 advance one bit per pulse on an external bit-rate enable, so a timer elsewhere sets their rate. A sticky transmit-complete flag tells software when the frame is nearly done, and software clears it with a pulse. The mode, the ninth bit and the rate choice are captured when the frame starts, so a change to them during a frame has no effect.

Top module: `legacy_uart_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `ser_out` is 1, `sclk_out` is 1 and `ti_flag` is 0 until a frame sets it.
- R2: A `wr_en` pulse while idle starts a frame whose first bit appears on the cycle after the write edge. `mode`, `ninth_bit` and `rate_fast` are captured at that edge, and later changes do not alter the frame.
- R3: Mode 2'b00 sends the 8 data bits LSB first on `ser_out`, each lasting DIV_SYNC (12) clocks. `sclk_out` is low for the first half of each bit and high for the second half.
- R4: Mode 2'b01 sends 10 bits: a 0 start bit, 8 data bits LSB first, then a 1 stop bit. Each bit advances on a `baud_tick` pulse.
- R5: Mode 2'b10 sends 11 bits: a 0 start bit, 8 data bits LSB first, the captured `ninth_bit`, then a 1 stop bit. Each bit lasts 32 clocks when `rate_fast`=1 and 64 clocks when `rate_fast`=0.
- R6: Mode 2'b11 sends the same 11-bit frame as mode 2'b10, but each bit advances on a `baud_tick` pulse.
- R7: `baud_tick` has no effect on the output waveform in modes 2'b00 and 2'b10.
- R8: `ti_flag` rises at the start of the stop bit in modes 2'b01 to 2'b11. In mode 2'b00 it rises once the eighth bit has ended. It stays at 1 until a `ti_clr` pulse, and a set in the same cycle as a clear wins.
- R9: A `wr_en` pulse during a frame is ignored, and the frame in progress completes unchanged.
- R10: `sclk_out` stays high throughout frames in modes 2'b01 to 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle strobe that loads the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| mode | input | 2 | Frame format: 00 sync shift, 01 10-bit, 10 11-bit fixed rate, 11 11-bit tick rate |
| ninth_bit | input | 1 | Ninth data bit for 11-bit frames |
| rate_fast | input | 1 | Mode 10 rate: 1 gives 32 clocks per bit, 0 gives 64 |
| baud_tick | input | 1 | Bit-rate enable for modes 01 and 11 |
| ti_clr | input | 1 | Clears the transmit-complete flag |
| ser_out | output | 1 | Serial data line, idles high |
| sclk_out | output | 1 | Shift clock in mode 00, otherwise high |
| ti_flag | output | 1 | Sticky transmit-complete flag |

## Verification
The bench sweeps every data byte through modes 00, 01 and 11, covering both ninth-bit values in mode 11. It sends a spread of bytes at both mode-10 rates, and it checks the line, the shift clock and the flag on every cycle of each frame. Each frame changes the mode, rate and ninth-bit inputs just after it starts. A design that failed to capture them would switch format or rate mid-frame and corrupt later bits.

Every third frame carries a second write mid-frame. A design that accepted it would restart the frame or emit the new byte. `baud_tick` toggles during internally timed frames, so a design whose rate mux was wrong would shorten those bits. The flag is checked for its exact rise: a design that set it at the end of the stop bit, or one bit early in mode 00, would show a mismatch. A clear after each frame shows that the flag is sticky and that it clears.

// File: rtl/legacy_uart_tx_pkg.sv
// Package: shared mode encoding and frame geometry for the legacy UART
// transmitter. Assumes frames never exceed FRAME_W bits.
package legacy_uart_tx_pkg;

    typedef enum logic [1:0] {
        MODE_SYNC   = 2'b00,
        MODE_ASYNC8 = 2'b01,
        MODE_FIX9   = 2'b10,
        MODE_VAR9   = 2'b11
    } tx_mode_e;

    localparam int FRAME_W = 11;
    localparam int IDX_W   = $clog2(FRAME_W);

    // Number of bit periods in a frame of the given format.
    function automatic logic [IDX_W-1:0] frame_len(input tx_mode_e m);
        case (m)
            MODE_SYNC:   frame_len = IDX_W'(8);
            MODE_ASYNC8: frame_len = IDX_W'(10);
            default:     frame_len = IDX_W'(11);
        endcase
    endfunction

    // True when the format takes its bit timing from the system clock.
    function automatic logic internal_rate(input tx_mode_e m);
        internal_rate = (m == MODE_SYNC) || (m == MODE_FIX9);
    endfunction

endpackage

// File: rtl/legacy_uart_tx_rate.sv
// Bit-rate generator: picks the internal divider or the external tick
// according to the captured mode. Assumes all divider values are >= 2 and
// that the divider restarts on every frame start.
module legacy_uart_tx_rate
    import legacy_uart_tx_pkg::*;
#(
    parameter int DIV_SYNC = 12,
    parameter int DIV_FAST = 32,
    parameter int DIV_SLOW = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     active,
    input  tx_mode_e mode_lat,
    input  logic     rate_lat,
    input  logic     baud_tick,
    output logic     bit_tick,
    output logic     first_half
);

    localparam int DIV_MAX  = (DIV_SYNC > DIV_FAST) ?
                              ((DIV_SYNC > DIV_SLOW) ? DIV_SYNC : DIV_SLOW) :
                              ((DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW);
    localparam int CNT_W    = $clog2(DIV_MAX);
    localparam int HALF_SYN = DIV_SYNC / 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             use_int;

    // Select the divider terminal count for the current format.
    always_comb begin
        if (mode_lat == MODE_SYNC)
            last = CNT_W'(DIV_SYNC - 1);
        else if (rate_lat)
            last = CNT_W'(DIV_FAST - 1);
        else
            last = CNT_W'(DIV_SLOW - 1);
    end

    assign use_int = internal_rate(mode_lat);

    // Divider counter: cleared on frame start, wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (active && use_int)
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end

    // Bit advance strobe and shift-clock phase.
    always_comb begin
        if (use_int)
            bit_tick = active && (cnt == last);
        else
            bit_tick = active && baud_tick;
        first_half = (cnt < CNT_W'(HALF_SYN));
    end

endmodule

// File: rtl/legacy_uart_tx_shift.sv
// Frame shifter: captures byte and controls on an idle write, shifts one
// bit per bit_tick LSB first, and flags the transmit-complete point.
// Assumes bit_tick is only high while active.
module legacy_uart_tx_shift
    import legacy_uart_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic [1:0]         mode,
    input  logic               ninth_bit,
    input  logic               rate_fast,
    input  logic               bit_tick,
    output logic               active,
    output logic               start,
    output tx_mode_e           mode_lat,
    output logic               rate_lat,
    output logic               ser_bit,
    output logic               ti_set,
    output logic [FRAME_W-1:0] shreg
);

    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   len;
    logic [FRAME_W-1:0] load_val;
    logic               last_bit;

    assign start    = wr_en && !active;
    assign len      = frame_len(mode_lat);
    assign last_bit = (idx == len - 1'b1);

    // Build the frame image for the requested format, bit 0 sent first.
    always_comb begin
        case (tx_mode_e'(mode))
            MODE_SYNC:   load_val = {3'b111, wr_data};
            MODE_ASYNC8: load_val = {2'b11, wr_data, 1'b0};
            default:     load_val = {1'b1, ninth_bit, wr_data, 1'b0};
        endcase
    end

    // Frame state: load on idle write, shift and count on each bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            idx      <= '0;
            shreg    <= '1;
            mode_lat <= MODE_SYNC;
            rate_lat <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            idx      <= '0;
            shreg    <= load_val;
            mode_lat <= tx_mode_e'(mode);
            rate_lat <= rate_fast;
        end else if (bit_tick) begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            if (last_bit) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Completion strobe: entry to stop bit, or end of the eighth sync bit.
    always_comb begin
        if (mode_lat == MODE_SYNC)
            ti_set = bit_tick && last_bit;
        else
            ti_set = bit_tick && (idx == len - IDX_W'(2));
    end

    assign ser_bit = active ? shreg[0] : 1'b1;

endmodule

// File: rtl/legacy_uart_tx_flag.sv
// Transmit-complete flag: sticky set, software clear, set has priority.
module legacy_uart_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ti_set,
    input  logic ti_clr,
    output logic ti_flag
);

    // Hold the flag until cleared; a simultaneous set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ti_flag <= 1'b0;
        else if (ti_set)
            ti_flag <= 1'b1;
        else if (ti_clr)
            ti_flag <= 1'b0;
    end

endmodule

// File: rtl/legacy_uart_tx.sv
// Top: four-format legacy UART transmitter. Connects the shifter, the rate
// generator and the completion flag, and forms the shift clock output.
// Assumes baud_tick is a single-cycle enable synchronous to clk.
module legacy_uart_tx
    import legacy_uart_tx_pkg::*;
#(
    parameter int DIV_SYNC = 12,
    parameter int DIV_FAST = 32,
    parameter int DIV_SLOW = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] mode,
    input  logic       ninth_bit,
    input  logic       rate_fast,
    input  logic       baud_tick,
    input  logic       ti_clr,
    output logic       ser_out,
    output logic       sclk_out,
    output logic       ti_flag
);

    logic               tx_active;
    logic               tx_start;
    tx_mode_e           mode_lat;
    logic               rate_lat;
    logic               bit_tick;
    logic               first_half;
    logic               ti_set;
    logic [FRAME_W-1:0] shreg;

    legacy_uart_tx_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .mode      (mode),
        .ninth_bit (ninth_bit),
        .rate_fast (rate_fast),
        .bit_tick  (bit_tick),
        .active    (tx_active),
        .start     (tx_start),
        .mode_lat  (mode_lat),
        .rate_lat  (rate_lat),
        .ser_bit   (ser_out),
        .ti_set    (ti_set),
        .shreg     (shreg)
    );

    legacy_uart_tx_rate #(
        .DIV_SYNC (DIV_SYNC),
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (tx_start),
        .active     (tx_active),
        .mode_lat   (mode_lat),
        .rate_lat   (rate_lat),
        .baud_tick  (baud_tick),
        .bit_tick   (bit_tick),
        .first_half (first_half)
    );

    legacy_uart_tx_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ti_set  (ti_set),
        .ti_clr  (ti_clr),
        .ti_flag (ti_flag)
    );

    // Shift clock: low in the first half of each sync-mode bit, else high.
    always_comb begin
        sclk_out = !(tx_active && (mode_lat == MODE_SYNC) && first_half);
    end

endmodule

// File: rtl/legacy_uart_tx_checker.sv
// Checker: temporal properties of the transmitter, bound into the top.
module legacy_uart_tx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        ti_clr,
    input logic        ser_out,
    input logic        sclk_out,
    input logic        ti_flag,
    input logic        active,
    input logic [1:0]  mode_lat,
    input logic        bit_tick,
    input logic        ti_set,
    input logic [10:0] shreg
);

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (ser_out && sclk_out)); // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && (mode_lat != 2'b00)) |-> !ser_out); // R4

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(mode_lat)); // R2

    AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_en && !bit_tick) |=> $stable(shreg)); // R9

    AST_ASYNC_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lat != 2'b00) |-> sclk_out); // R10

    AST_TI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ti_flag && !ti_clr) |=> ti_flag); // R8

    AST_TI_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ti_set |=> ti_flag); // R8

endmodule

bind legacy_uart_tx legacy_uart_tx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .ti_clr   (ti_clr),
    .ser_out  (ser_out),
    .sclk_out (sclk_out),
    .ti_flag  (ti_flag),
    .active   (tx_active),
    .mode_lat (mode_lat),
    .bit_tick (bit_tick),
    .ti_set   (ti_set),
    .shreg    (shreg)
);

// File: tb/legacy_uart_tx_test.sv
`timescale 1ns/100ps
// Bench: sweeps bytes through all four formats and checks every cycle.
module legacy_uart_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] mode = 2'b00;
    logic       ninth_bit = 1'b0;
    logic       rate_fast = 1'b0;
    logic       baud_tick = 1'b0;
    logic       ti_clr = 1'b0;
    logic       ser_out;
    logic       sclk_out;
    logic       ti_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int frames = 0;

    always #2.5 clk = ~clk;

    legacy_uart_tx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .mode      (mode),
        .ninth_bit (ninth_bit),
        .rate_fast (rate_fast),
        .baud_tick (baud_tick),
        .ti_clr    (ti_clr),
        .ser_out   (ser_out),
        .sclk_out  (sclk_out),
        .ti_flag   (ti_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Expected line value for bit k of a frame.
    function automatic logic exp_bit(input logic [1:0] m, input logic [7:0] d,
                                     input logic nb, input int k);
        if (m == 2'b00) return d[k];
        if (k == 0) return 1'b0;
        if (k <= 8) return d[k-1];
        if (k == 9) return (m == 2'b01) ? 1'b1 : nb;
        return 1'b1;
    endfunction

    // Send one frame and check line, shift clock and flag on every cycle.
    task automatic send(input logic [1:0] m, input logic [7:0] d,
                        input logic nb, input logic rf);
        int len;
        int per;
        bit busy_wr;
        string rq;
        len = (m == 2'b00) ? 8 : ((m == 2'b01) ? 10 : 11);
        per = (m == 2'b00) ? 12 : ((m == 2'b10) ? (rf ? 32 : 64) : 4);
        rq  = (m == 2'b00) ? "R3" : ((m == 2'b01) ? "R4" : ((m == 2'b10) ? "R5" : "R6"));
        busy_wr = (frames % 3 == 0);
        frames++;
        wr_en = 1'b1; wr_data = d; mode = m; ninth_bit = nb; rate_fast = rf;
        @(negedge clk);
        wr_en = 1'b0;
        for (int c = 0; c <= len * per; c++) begin
            if (c == 1) begin
                mode = m ^ 2'b01; ninth_bit = ~nb; rate_fast = ~rf; // R2 capture
                if (busy_wr) begin wr_en = 1'b1; wr_data = ~d; end  // R9
            end else begin
                wr_en = 1'b0;
            end
            // R7: tick toggles freely in internally timed formats
            if (m == 2'b00 || m == 2'b10) baud_tick = c[0];
            else baud_tick = (c % per == per - 1);
            if (c < len * per) begin
                check(busy_wr ? "R9" : rq, ser_out, exp_bit(m, d, nb, c / per));
                if (m == 2'b00)
                    check("R3", sclk_out, (c % per) >= per / 2);
                else
                    check("R10", sclk_out, 1'b1);
                if (m == 2'b00) check("R8", ti_flag, 1'b0);
                else check("R8", ti_flag, c >= (len - 1) * per);
            end else begin
                check("R1", ser_out, 1'b1);
                check("R1", sclk_out, 1'b1);
                check("R8", ti_flag, 1'b1);
            end
            @(negedge clk);
        end
        baud_tick = 1'b0; wr_en = 1'b0;
        check("R8", ti_flag, 1'b1);
        ti_clr = 1'b1;
        @(negedge clk);
        ti_clr = 1'b0;
        check("R8", ti_flag, 1'b0);
        check("R1", ser_out, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", ser_out, 1'b1);
        check("R1", sclk_out, 1'b1);
        check("R1", ti_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", ser_out, 1'b1);
        check("R1", ti_flag, 1'b0);
        for (int i = 0; i < 256; i++) send(2'b00, 8'(i), 1'b0, 1'b0);
        for (int i = 0; i < 256; i++) send(2'b01, 8'(i), i[0], 1'b0);
        for (int i = 0; i < 256; i++) begin
            send(2'b11, 8'(i), 1'b0, 1'b0);
            send(2'b11, 8'(i), 1'b1, 1'b1);
        end
        for (int i = 0; i < 16; i++) begin
            send(2'b10, 8'(i * 17 + 3), i[0], 1'b1);
            send(2'b10, 8'(i * 29 + 5), ~i[0], 1'b0);
        end
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule